// File: doc/BRIEF.md
# Shared Frame-Memory Arbiter with Queued Pixel Writes

This block lets two clients share one memory port. A display fetcher asks for whole-line burst reads, and a pixel-drawing engine produces single-byte writes. Display refills cannot wait for long, so the fetcher always wins when both clients are pending. The drawing engine never talks to memory directly. Its writes enter a small queue, so it can keep producing pixels while the memory is busy with a burst.

Ownership changes only at transfer boundaries. Once a transfer starts, it runs to its last acknowledge. A single write gives up the port after its one acknowledge. A burst gives it up only after the final beat. Every release is followed by at least one cycle in which nobody owns the port. The memory side sees a held request plus a per-beat acknowledge. Read data is passed straight through to the fetcher.

Top module: `vidmem_arb`

## Requirements
- R1: `owner` never has more than one bit set; bit 0 means the display fetcher owns memory and bit 1 means the write queue owns it.
- R2: `m_req` is high exactly while `owner` is non-zero, and `m_we` is high exactly while bit 1 of `owner` is set.
- R3: A burst is never preempted. While the fetcher owns memory and the final beat has not been acknowledged, `owner` stays at 01 and `m_addr` stays stable, whatever the other client does.
- R4: A queued write keeps ownership until its single `m_ack` and releases on the following clock edge.
- R5: A burst request with `vr_len` = N transfers N beats, where the value 0 stands for 2^LW beats (16 by default). `m_addr` carries the start address and `m_len` carries `vr_len`. Each acknowledged beat gives `vr_rvalid`=1 with `vr_rdata` equal to `m_rdata`. Ownership ends on the edge after the Nth acknowledge.
- R6: If `vr_req` is high while no one owns memory, the next owner is the fetcher, even when writes are queued.
- R7: Queued writes reach memory in the order they were accepted, each with its own address and data byte unchanged.
- R8: The queue holds 16 entries. With the memory never acknowledging, exactly 17 writes are accepted (16 queued and 1 in flight), after which `dw_ready` stays low.
- R9: After the acknowledge that ends any transfer, `owner` is 00 for at least the next cycle.
- R10: While reset is asserted and right after it, `owner` is 00, `m_req` is 0 and `dw_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vr_req | input | 1 | Fetcher burst request, held until it owns memory |
| vr_addr | input | AW | Burst start address |
| vr_len | input | LW | Burst beat count (0 means 2^LW) |
| vr_rvalid | output | 1 | Read beat valid for the fetcher |
| vr_rdata | output | DW | Read beat data |
| dw_valid | input | 1 | Drawing engine offers a write |
| dw_addr | input | AW | Write address |
| dw_data | input | DW | Write data byte |
| dw_ready | output | 1 | Queue can accept a write |
| owner | output | 2 | One-hot current owner (bit 0 fetcher, bit 1 writer) |
| m_req | output | 1 | Memory request, held for the whole transfer |
| m_we | output | 1 | Transfer is a write |
| m_addr | output | AW | Transfer address |
| m_len | output | LW | Transfer beat count (1 for writes) |
| m_wdata | output | DW | Write data |
| m_ack | input | 1 | Memory accepts or returns one beat |
| m_rdata | input | DW | Memory read data |

## Verification
The bench sweeps every burst length from 1 to 16 with acknowledge latencies of zero, one and two cycles. This separates a correct beat counter from one that is off by one or that mishandles the 0-encodes-16 case. A write stream runs against a memory that never acknowledges, which fixes the exact queue capacity. A write is held mid-transfer while a burst request arrives, which shows both that the write is not preempted and that the fetcher wins the next boundary. Finally, concurrent write streams and bursts are interleaved, and the memory-side write log is compared with the acceptance order.

// File: rtl/vidmem_arb_pkg.sv
package vidmem_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_VID  = 2'd1,
    ST_WR   = 2'd2
  } arb_state_t;
  localparam int OWN_VID = 0;
  localparam int OWN_WR  = 1;
endpackage

// File: rtl/vidmem_wq.sv
module vidmem_wq #(
  parameter int EW    = 24,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [EW-1:0] din,
  input  logic          pop,
  output logic [EW-1:0] dout,
  output logic          full,
  output logic          empty
);
  localparam int PW = $clog2(DEPTH);

  logic [EW-1:0] slot [DEPTH];
  logic [PW:0]   wp_q, wp_d, rp_q, rp_d;
  logic          wr_en, rd_en;

  always_comb begin
    wr_en = push && !full;
    rd_en = pop && !empty;
    wp_d  = wp_q + {{PW{1'b0}}, wr_en};
    rp_d  = rp_q + {{PW{1'b0}}, rd_en};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) slot[wp_q[PW-1:0]] <= din;
  end

  assign dout  = slot[rp_q[PW-1:0]];
  assign empty = (wp_q == rp_q);
  assign full  = (wp_q[PW] != rp_q[PW]) && (wp_q[PW-1:0] == rp_q[PW-1:0]);
endmodule

// File: rtl/vidmem_seq.sv
module vidmem_seq
  import vidmem_arb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vr_req,
  input  logic [AW-1:0] vr_addr,
  input  logic [LW-1:0] vr_len,
  input  logic          wq_empty,
  input  logic [AW-1:0] wq_addr,
  input  logic [DW-1:0] wq_data,
  output logic          wq_pop,
  input  logic          m_ack,
  output logic [1:0]    owner,
  output logic          m_req,
  output logic          m_we,
  output logic [AW-1:0] m_addr,
  output logic [LW-1:0] m_len,
  output logic [DW-1:0] m_wdata
);
  localparam logic [LW-1:0] ONE = {{(LW-1){1'b0}}, 1'b1};

  arb_state_t    st_q, st_d;
  logic [LW-1:0] cnt_q, cnt_d, len_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          load_vid, load_wr, last_beat;

  assign last_beat = (cnt_q == (len_q - ONE));

  always_comb begin
    st_d     = st_q;
    load_vid = 1'b0;
    load_wr  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (vr_req) begin
          st_d     = ST_VID;
          load_vid = 1'b1;
        end else if (!wq_empty) begin
          st_d    = ST_WR;
          load_wr = 1'b1;
        end
      end
      ST_VID:  if (m_ack && last_beat) st_d = ST_IDLE;
      ST_WR:   if (m_ack) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load_vid)                    cnt_d = '0;
    else if (st_q == ST_VID && m_ack) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
      data_q <= '0;
    end else begin
      if (load_vid) begin
        addr_q <= vr_addr;
        len_q  <= vr_len;
      end else if (load_wr) begin
        addr_q <= wq_addr;
        len_q  <= ONE;
        data_q <= wq_data;
      end
    end
  end

  assign wq_pop         = load_wr;
  assign owner[OWN_VID] = (st_q == ST_VID);
  assign owner[OWN_WR]  = (st_q == ST_WR);
  assign m_req          = (st_q != ST_IDLE);
  assign m_we           = (st_q == ST_WR);
  assign m_addr         = addr_q;
  assign m_len          = len_q;
  assign m_wdata        = data_q;
endmodule

// File: rtl/vidmem_arb.sv
module vidmem_arb #(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int LW    = 4,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vr_req,
  input  logic [AW-1:0] vr_addr,
  input  logic [LW-1:0] vr_len,
  output logic          vr_rvalid,
  output logic [DW-1:0] vr_rdata,
  input  logic          dw_valid,
  input  logic [AW-1:0] dw_addr,
  input  logic [DW-1:0] dw_data,
  output logic          dw_ready,
  output logic [1:0]    owner,
  output logic          m_req,
  output logic          m_we,
  output logic [AW-1:0] m_addr,
  output logic [LW-1:0] m_len,
  output logic [DW-1:0] m_wdata,
  input  logic          m_ack,
  input  logic [DW-1:0] m_rdata
);
  localparam int EW = AW + DW;

  logic [EW-1:0] q_dout;
  logic          q_full, q_empty, q_pop;

  vidmem_wq #(.EW(EW), .DEPTH(DEPTH)) u_wq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (dw_valid),
    .din   ({dw_addr, dw_data}),
    .pop   (q_pop),
    .dout  (q_dout),
    .full  (q_full),
    .empty (q_empty)
  );

  vidmem_seq #(.AW(AW), .DW(DW), .LW(LW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .vr_req   (vr_req),
    .vr_addr  (vr_addr),
    .vr_len   (vr_len),
    .wq_empty (q_empty),
    .wq_addr  (q_dout[EW-1:DW]),
    .wq_data  (q_dout[DW-1:0]),
    .wq_pop   (q_pop),
    .m_ack    (m_ack),
    .owner    (owner),
    .m_req    (m_req),
    .m_we     (m_we),
    .m_addr   (m_addr),
    .m_len    (m_len),
    .m_wdata  (m_wdata)
  );

  assign dw_ready  = !q_full;
  assign vr_rvalid = owner[0] && m_ack;
  assign vr_rdata  = m_rdata;
endmodule

// File: rtl/vidmem_arb_chk.sv
module vidmem_arb_chk #(
  parameter int AW = 16,
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vr_req,
  input logic [1:0]    owner,
  input logic          m_req,
  input logic          m_we,
  input logic          m_ack,
  input logic [AW-1:0] m_addr,
  input logic [LW-1:0] m_len
);
  localparam logic [LW-1:0] ONE = {{(LW-1){1'b0}}, 1'b1};

  logic [LW-1:0] beats_q;
  logic          final_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         beats_q <= '0;
    else if (!owner[0]) beats_q <= '0;
    else if (m_ack)     beats_q <= beats_q + ONE;
  end

  assign final_beat = m_ack && (beats_q == (m_len - ONE));

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner));

  a_r2_req_owned: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> ((owner != 2'b00) && (m_we == owner[1])));

  a_r3_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (owner[0] && !final_beat) |=> (owner[0] && $stable(m_addr)));

  a_r4_wr_release: assert property (@(posedge clk) disable iff (!rst_n)
    (owner[1] && m_ack) |=> (owner == 2'b00));

  a_r5_burst_end: assert property (@(posedge clk) disable iff (!rst_n)
    (owner[0] && final_beat) |=> (owner == 2'b00));

  a_r6_priority: assert property (@(posedge clk) disable iff (!rst_n)
    ((owner == 2'b00) && vr_req) |=> owner[0]);

  a_r9_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ((owner == 2'b00) && $past(owner != 2'b00)) |-> !m_req);
endmodule

bind vidmem_arb vidmem_arb_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .vr_req (vr_req),
  .owner  (owner),
  .m_req  (m_req),
  .m_we   (m_we),
  .m_ack  (m_ack),
  .m_addr (m_addr),
  .m_len  (m_len)
);

// File: tb/vidmem_arb_test.sv
module vidmem_arb_test;
  logic        clk, rst_n;
  logic        vr_req, vr_rvalid, dw_valid, dw_ready, m_req, m_we, m_ack;
  logic [15:0] vr_addr, dw_addr, m_addr;
  logic [3:0]  vr_len, m_len;
  logic [7:0]  vr_rdata, dw_data, m_wdata, m_rdata;
  logic [1:0]  owner;

  int errors = 0, checks = 0;
  int lat = 0, lat_cnt = 0, beat = 0, vbeats = 0, exp_len = 1;
  bit stall = 0, pend_end = 0, done = 0;
  logic [15:0] exp_addr = 0;
  logic [15:0] exp_a [128];
  logic [7:0]  exp_d [128];
  logic [15:0] log_a [128];
  logic [7:0]  log_d [128];
  int nexp = 0, nlog = 0;

  vidmem_arb uut (
    .clk(clk), .rst_n(rst_n), .vr_req(vr_req), .vr_addr(vr_addr), .vr_len(vr_len),
    .vr_rvalid(vr_rvalid), .vr_rdata(vr_rdata), .dw_valid(dw_valid), .dw_addr(dw_addr),
    .dw_data(dw_data), .dw_ready(dw_ready), .owner(owner), .m_req(m_req), .m_we(m_we),
    .m_addr(m_addr), .m_len(m_len), .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // memory model and per-cycle monitor, evaluated at falling edges
  initial begin
    m_ack = 0; m_rdata = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (pend_end) begin
          chk(owner == 2'b00, "R9 idle after release", owner, 0);
          pend_end = 0;
        end
        chk($onehot0(owner), "R1 owner one-hot", owner, 0);
        if (m_req) chk((owner != 0) && (m_we == owner[1]), "R2 req/we vs owner", {m_we, owner}, {owner[1], owner});
        else chk(owner == 0, "R2 no req means no owner", owner, 0);
      end
      m_ack = 0;
      if (!m_req) begin
        lat_cnt = 0; beat = 0;
      end else if (!stall) begin
        if (lat_cnt >= lat) begin
          m_ack = 1; lat_cnt = 0;
          if (m_we) begin
            log_a[nlog] = m_addr; log_d[nlog] = m_wdata; nlog++;
            pend_end = 1;
          end else begin
            m_rdata = m_addr[7:0] + beat[7:0];
            if (beat == 0) begin
              chk(m_addr == exp_addr, "R5 burst address", m_addr, exp_addr);
              chk(m_len == exp_len[3:0], "R5 burst length field", m_len, exp_len[3:0]);
            end
            #1;
            chk(vr_rvalid && vr_rdata == m_rdata, "R5 beat passthrough", {vr_rvalid, vr_rdata}, {1'b1, m_rdata});
            beat++; vbeats++;
            if (beat == exp_len) pend_end = 1;
          end
        end else lat_cnt++;
      end
    end
  end

  task automatic push(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    dw_valid = 1; dw_addr = a; dw_data = d;
    while (!dw_ready) @(negedge clk);
    exp_a[nexp] = a; exp_d[nexp] = d; nexp++;
    @(negedge clk);
    dw_valid = 0;
  endtask

  task automatic burst(input logic [15:0] a, input int len);
    vbeats = 0; exp_len = len; exp_addr = a;
    @(negedge clk);
    vr_req = 1; vr_addr = a; vr_len = len[3:0];
    do @(negedge clk); while (!owner[0]);
    vr_req = 0;
    do @(negedge clk); while (owner[0]);
    chk(vbeats == len, "R5 beat count", vbeats, len);
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int acc;
    rst_n = 0; vr_req = 0; vr_addr = 0; vr_len = 0; dw_valid = 0; dw_addr = 0; dw_data = 0;
    settle(3);
    chk(owner == 0 && !m_req && dw_ready, "R10 reset state", {owner, m_req, dw_ready}, 4'b0001);
    rst_n = 1;
    settle(2);
    chk(owner == 0 && !m_req && dw_ready, "R10 after reset", {owner, m_req, dw_ready}, 4'b0001);

    // R4 R7: single writes at several latencies
    for (int i = 0; i < 6; i++) begin
      lat = i % 3;
      push(16'h0100 + 16'(i * 3), 8'(8'h11 * i));
    end
    settle(20);

    // R5 R3: sweep all burst lengths and latencies
    for (int n = 1; n <= 16; n++) begin
      for (int l = 0; l < 3; l++) begin
        lat = l;
        burst(16'h4000 + 16'(n * 64), n);
      end
    end

    // R8: capacity with a stalled memory
    lat = 0; stall = 1;
    settle(2);
    acc = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      dw_valid = 1; dw_addr = 16'h0800 + 16'(acc); dw_data = 8'(8'hA0 + acc);
      if (dw_ready) begin
        exp_a[nexp] = dw_addr; exp_d[nexp] = dw_data; nexp++; acc++;
      end
    end
    @(negedge clk);
    dw_valid = 0;
    chk(acc == 17, "R8 accepted writes while stalled", acc, 17);
    chk(!dw_ready, "R8 ready low when full", dw_ready, 0);
    chk(owner == 2'b10, "R4 write held without ack", owner, 2'b10);
    stall = 0;
    settle(60);

    // R6 R3: burst request arrives during a stalled write with writes queued
    stall = 1;
    settle(2);
    for (int i = 0; i < 4; i++) push(16'h0900 + 16'(i), 8'(8'h50 + i));
    settle(3);
    chk(owner == 2'b10, "R3 write not preempted", owner, 2'b10);
    vbeats = 0; exp_len = 2; exp_addr = 16'h0300;
    vr_req = 1; vr_addr = 16'h0300; vr_len = 4'd2;
    settle(3);
    chk(owner == 2'b10, "R3 write not preempted by burst request", owner, 2'b10);
    stall = 0;
    do @(negedge clk); while (owner != 0);
    @(negedge clk);
    chk(owner == 2'b01, "R6 fetcher wins boundary", owner, 2'b01);
    vr_req = 0;
    do @(negedge clk); while (owner[0]);
    chk(vbeats == 2, "R5 beat count after priority", vbeats, 2);
    settle(30);

    // R7: concurrent writes and bursts
    lat = 1;
    fork
      begin
        for (int i = 0; i < 20; i++) push(16'h1000 + 16'(i), 8'(i * 7));
      end
      begin
        burst(16'h2000, 5);
        burst(16'h2100, 3);
      end
    join
    settle(60);

    chk(nlog == nexp, "R7 write count", nlog, nexp);
    for (int i = 0; i < nexp; i++)
      chk(log_a[i] == exp_a[i] && log_d[i] == exp_d[i], "R7 write order and content",
          {log_a[i], log_d[i]}, {exp_a[i], exp_d[i]});
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule